// File: doc/BRIEF.md
# Freezable Channel Activity Counters

This block keeps four saturating 32-bit counters that measure how a radio channel is used: every clock cycle, cycles in which the channel is sensed busy, cycles spent receiving a frame and cycles spent sending one. The radio and the channel sensing are outside the block. They arrive as three status inputs: a clear-channel flag, a receive-active flag and a transmit-active flag.

Software controls the counters through a small register port with address, read strobe and write strobe. A single hold bit stops all four counters together. The usual sequence is: set the hold bit, read the four counters, write zero to each, then clear the hold bit. The counters are frozen for the whole sequence, so the values read form one consistent set and no activity falls between the read and the clear.

Each rising edge of the hold bit also starts a sequential divider. It computes the idle listening time in milliseconds: (all cycles − receive cycles − transmit cycles) / (clock MHz × 1000), with a negative difference taken as zero. The divider is a three-state machine:
- DIV_IDLE goes to DIV_SHIFT on a start pulse.
- DIV_SHIFT runs one quotient bit per cycle and goes to DIV_DONE after the last bit.
- DIV_DONE raises the done strobe for one cycle and returns to DIV_IDLE.

Top module: `chan_activity_counters`

## Requirements
- R1: During reset and straight after it, all counters read 0, the control register reads 0, `listen_ms` is 0 and `listen_done` is 0.
- R2: While the hold bit is 0, the all-cycles counter (address 1) rises by one on every clock.
- R3: While the hold bit is 0, three counters rise on each clock where their condition holds. The busy counter (address 2) counts when `chan_clear` is 0. The receive counter (address 3) counts when `rx_active` is 1. The transmit counter (address 4) counts when `tx_active` is 1.
- R4: While the hold bit (control register address 0, bit 0) is 1, none of the four counters changes, whatever the status inputs do.
- R5: A counter that reaches all ones stays at all ones instead of wrapping.
- R6: A write to a counter address loads `wr_data` into that counter. A write in the same cycle as an increment wins over the increment. Writing zero clears the counter.
- R7: A read returns its value on `rd_data` one clock after `rd_en`. Address 0 gives the hold bit in bit 0, addresses 1 to 4 give the counters, and addresses 5 to 7 give 0.
- R8: Each 0-to-1 change of the hold bit starts the divider. Within 40 cycles `listen_done` pulses for exactly one cycle. In that cycle `listen_ms` equals floor((all − receive − transmit) / (CLK_MHZ × 1000)) over the frozen values, and `listen_ms` keeps that value until the next result.
- R9: When receive plus transmit is larger than the all-cycles count, the listen time is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_clear | input | 1 | Channel sensed clear (busy when 0) |
| rx_active | input | 1 | A frame is being received |
| tx_active | input | 1 | A frame is being transmitted |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wr_data | input | CNT_W | Write data |
| rd_data | output | CNT_W | Read data, one cycle after rd_en |
| listen_ms | output | CNT_W | Last listen-time result in milliseconds |
| listen_done | output | 1 | One-cycle strobe when listen_ms is updated |

## Verification
A counter whose enable decodes wrongly shows up on the first read after a window: the count then disagrees with the number of cycles, taken from the input pattern, in which its condition held. A hold that leaks shows as counts that drift between two reads of a frozen block. A wrong wrap shows as a small value after the saturation window. A divider that starts late, runs a wrong number of steps or stops in a wrong state shows as a missing strobe within the bound, or as a quotient that disagrees with the value worked out from the written counters. That quotient is checked on the same cycle as the strobe.

// File: rtl/chanact_pkg.sv
package chanact_pkg;

    localparam int ADDR_W  = 3;
    localparam int NUM_CNT = 4;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL  = 3'd0,
        REG_TOTAL = 3'd1,
        REG_BUSY  = 3'd2,
        REG_RXF   = 3'd3,
        REG_TXF   = 3'd4
    } reg_addr_e;

    typedef enum logic [1:0] {
        DIV_IDLE,
        DIV_SHIFT,
        DIV_DONE
    } div_state_e;

endpackage

// File: rtl/act_counter.sv
module act_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    input  logic         wr_i,
    input  logic [W-1:0] wr_data_i,
    output logic [W-1:0] count_o
);
    localparam logic [W-1:0] ALL_ONES = '1;

    logic [W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (wr_i) begin
            count_q <= wr_data_i;
        end else if (inc_i && (count_q != ALL_ONES)) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign count_o = count_q;

endmodule

// File: rtl/listen_divider.sv
module listen_divider
    import chanact_pkg::*;
#(
    parameter int W       = 32,
    parameter int DIVISOR = 200000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [W-1:0] dividend_i,
    output logic [W-1:0] quot_o,
    output logic         done_o
);
    localparam int           SW      = $clog2(W);
    localparam logic [W:0]   DIV_EXT = (W+1)'(DIVISOR);
    localparam logic [SW-1:0] LAST   = SW'(W-1);

    div_state_e state_q, state_d;

    logic [W:0]    rem_q;
    logic [W-1:0]  quo_q;
    logic [W-1:0]  result_q;
    logic [SW-1:0] step_q;
    logic [W:0]    trial;
    logic          fits;

    assign trial = {rem_q[W-1:0], quo_q[W-1]};
    assign fits  = (trial >= DIV_EXT);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= DIV_IDLE;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        done_o  = 1'b0;
        unique case (state_q)
            DIV_IDLE:  if (start_i) state_d = DIV_SHIFT;
            DIV_SHIFT: if (step_q == LAST) state_d = DIV_DONE;
            DIV_DONE: begin
                done_o  = 1'b1;
                state_d = DIV_IDLE;
            end
            default:   state_d = DIV_IDLE;
        endcase
    end

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q    <= '0;
            quo_q    <= '0;
            step_q   <= '0;
            result_q <= '0;
        end else begin
            unique case (state_q)
                DIV_IDLE: begin
                    if (start_i) begin
                        rem_q  <= '0;
                        quo_q  <= dividend_i;
                        step_q <= '0;
                    end
                end
                DIV_SHIFT: begin
                    rem_q  <= fits ? (trial - DIV_EXT) : trial;
                    quo_q  <= {quo_q[W-2:0], fits};
                    step_q <= step_q + 1'b1;
                    if (step_q == LAST) result_q <= {quo_q[W-2:0], fits};
                end
                default: ;
            endcase
        end
    end

    assign quot_o = result_q;

endmodule

// File: rtl/chan_activity_counters.sv
module chan_activity_counters
    import chanact_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int CLK_MHZ = 200
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  chan_clear,
    input  logic                  rx_active,
    input  logic                  tx_active,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [CNT_W-1:0]      wr_data,
    output logic [CNT_W-1:0]      rd_data,
    output logic [CNT_W-1:0]      listen_ms,
    output logic                  listen_done
);
    localparam int IDX_TOTAL = 0;
    localparam int IDX_RXF   = 2;
    localparam int IDX_TXF   = 3;
    localparam int TICKS_MS  = CLK_MHZ * 1000;

    logic freeze_q, freeze_d;
    logic [NUM_CNT-1:0]            inc_vec;
    logic [NUM_CNT-1:0]            wr_vec;
    logic [NUM_CNT-1:0][CNT_W-1:0] cnt;
    logic [CNT_W+1:0]              diff;
    logic [CNT_W-1:0]              dividend;
    logic [CNT_W-1:0]              rd_next;
    logic                          start;

    // hold control
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            freeze_q <= 1'b0;
            freeze_d <= 1'b0;
        end else begin
            if (wr_en && (addr == REG_CTRL)) freeze_q <= wr_data[0];
            freeze_d <= freeze_q;
        end
    end

    assign inc_vec = freeze_q ? '0 : {tx_active, rx_active, ~chan_clear, 1'b1};

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        assign wr_vec[i] = wr_en && (addr == ADDR_W'(i + 1));
        act_counter #(.W(CNT_W)) u_cnt (
            .clk       (clk),
            .rst_n     (rst_n),
            .inc_i     (inc_vec[i]),
            .wr_i      (wr_vec[i]),
            .wr_data_i (wr_data),
            .count_o   (cnt[i])
        );
    end

    // read port
    always_comb begin
        unique case (addr)
            REG_CTRL:  rd_next = {{(CNT_W-1){1'b0}}, freeze_q};
            REG_TOTAL: rd_next = cnt[0];
            REG_BUSY:  rd_next = cnt[1];
            REG_RXF:   rd_next = cnt[2];
            REG_TXF:   rd_next = cnt[3];
            default:   rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_next;
    end

    // listen time
    assign diff = {2'b00, cnt[IDX_TOTAL]} - {2'b00, cnt[IDX_RXF]} - {2'b00, cnt[IDX_TXF]};
    assign dividend = (diff[CNT_W+1:CNT_W] != 2'b00) ? '0 : diff[CNT_W-1:0];
    assign start = freeze_q & ~freeze_d;

    listen_divider #(.W(CNT_W), .DIVISOR(TICKS_MS)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .dividend_i (dividend),
        .quot_o     (listen_ms),
        .done_o     (listen_done)
    );

endmodule

// File: rtl/chanact_checker.sv
module chanact_checker
    import chanact_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            wr_en,
    input logic                            rd_en,
    input logic [ADDR_W-1:0]               addr,
    input logic [CNT_W-1:0]                wr_data,
    input logic [CNT_W-1:0]                rd_data,
    input logic                            freeze_q,
    input logic [NUM_CNT-1:0][CNT_W-1:0]   cnt_all,
    input logic                            listen_done
);
    localparam logic [CNT_W-1:0] ALL_ONES = '1;

    logic wr_total;
    logic wr_any_cnt;
    assign wr_total   = wr_en && (addr == REG_TOTAL);
    assign wr_any_cnt = wr_en && (addr >= REG_TOTAL) && (addr <= REG_TXF);

    p_total_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!freeze_q && !wr_total && cnt_all[0] != ALL_ONES)
        |=> cnt_all[0] == $past(cnt_all[0]) + 1'b1);

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze_q && !wr_any_cnt) |=> $stable(cnt_all));

    p_saturate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_all[0] == ALL_ONES && !wr_total) |=> cnt_all[0] == ALL_ONES);

    p_write_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_total |=> cnt_all[0] == $past(wr_data));

    p_read_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == REG_TOTAL) |=> rd_data == $past(cnt_all[0]));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        listen_done |=> !listen_done);

endmodule

bind chan_activity_counters chanact_checker #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .addr        (addr),
    .wr_data     (wr_data),
    .rd_data     (rd_data),
    .freeze_q    (freeze_q),
    .cnt_all     (cnt),
    .listen_done (listen_done)
);

// File: tb/tb_chan_activity_counters.sv
`timescale 1ns/1ps
module tb_chan_activity_counters;

    localparam int  CNT_W   = 32;
    localparam int  CLK_MHZ = 200;
    localparam longint MAXV = 64'hFFFF_FFFF;

    logic clk = 1'b0;
    logic rst_n;
    logic chan_clear, rx_active, tx_active;
    logic wr_en, rd_en;
    logic [2:0] addr;
    logic [CNT_W-1:0] wr_data, rd_data, listen_ms;
    logic listen_done;

    always #2.5 clk = ~clk;

    chan_activity_counters #(.CNT_W(CNT_W), .CLK_MHZ(CLK_MHZ)) dut (
        .clk(clk), .rst_n(rst_n), .chan_clear(chan_clear), .rx_active(rx_active),
        .tx_active(tx_active), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .listen_ms(listen_ms),
        .listen_done(listen_done)
    );

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;
    longint m [4];

    typedef struct {
        logic [CNT_W-1:0] exp;
        string            tag;
    } sb_item_t;
    sb_item_t sb_q[$];
    logic rd_seen;

    task automatic chk(input logic [CNT_W-1:0] act, input logic [CNT_W-1:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: compare read data against queued expectations
    always @(posedge clk) rd_seen <= (rst_n === 1'b1) && rd_en;
    always @(negedge clk) begin
        if (rd_seen === 1'b1) begin
            if (sb_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R7 actual=%0h expected=queued item", rd_data);
            end else begin
                sb_item_t it;
                it = sb_q.pop_front();
                chk(rd_data, it.exp, it.tag);
            end
        end
    end

    task automatic bus_write(input int a, input logic [CNT_W-1:0] d);
        wr_en = 1'b1; addr = 3'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input int a, input logic [CNT_W-1:0] exp, input string tag);
        sb_item_t it;
        it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        rd_en = 1'b1; addr = 3'(a);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wr_cnt(input int idx, input longint v);
        bus_write(idx + 1, v[CNT_W-1:0]);
        m[idx] = v;
    endtask

    task automatic check_all(input string tag);
        for (int i = 0; i < 4; i++) bus_read(i + 1, m[i][CNT_W-1:0], tag);
    endtask

    function automatic longint sat_inc(input longint v);
        return (v >= MAXV) ? MAXV : v + 1;
    endfunction

    function automatic logic [CNT_W-1:0] exp_listen();
        longint num;
        num = m[0] - m[2] - m[3];
        if (num < 0) return '0;
        return CNT_W'(num / (CLK_MHZ * 1000));
    endfunction

    // status pattern: {tx, rx, clear}
    function automatic logic [2:0] pat(input int mode, input int i);
        case (mode)
            0:       return {(i % 5 == 1), (i % 3 == 0), 1'b0};
            2:       return {1'b0, 1'b1, 1'(i % 2)};
            default: return 3'b001;
        endcase
    endfunction

    // unfreeze, count for n edges, refreeze on the last edge
    task automatic run_window(input int n, input int mode);
        logic [2:0] p;
        bus_write(0, 0);
        for (int i = 0; i < n; i++) begin
            p = pat(mode, i);
            chan_clear = p[0]; rx_active = p[1]; tx_active = p[2];
            m[0] = sat_inc(m[0]);
            if (!p[0]) m[1] = sat_inc(m[1]);
            if (p[1])  m[2] = sat_inc(m[2]);
            if (p[2])  m[3] = sat_inc(m[3]);
            if (i == n - 1) begin
                wr_en = 1'b1; addr = 3'd0; wr_data = 1;
            end
            @(negedge clk);
        end
        wr_en = 1'b0;
        chan_clear = 1'b1; rx_active = 1'b0; tx_active = 1'b0;
    endtask

    task automatic wait_done(input logic [CNT_W-1:0] exp, input string tag);
        int n = 0;
        while (listen_done !== 1'b1 && n < 40) begin
            @(negedge clk);
            n++;
        end
        checks++;
        if (listen_done !== 1'b1) begin
            fails++;
            $display("FAIL R8 actual=no strobe expected=strobe within 40 cycles");
        end else begin
            chk(listen_ms, exp, tag);
            @(negedge clk);
            chk({31'b0, listen_done}, 0, "R8 strobe one cycle");
            chk(listen_ms, exp, "R8 result held");
        end
    endtask

    initial begin
        rst_n = 1'b0; chan_clear = 1'b1; rx_active = 1'b0; tx_active = 1'b0;
        wr_en = 1'b0; rd_en = 1'b0; addr = '0; wr_data = '0;
        for (int i = 0; i < 4; i++) m[i] = 0;
        repeat (4) @(negedge clk);
        // R1: reset state at the ports
        chk(rd_data, 0, "R1 rd_data in reset");
        chk(listen_ms, 0, "R1 listen_ms in reset");
        chk({31'b0, listen_done}, 0, "R1 done in reset");
        rst_n = 1'b1;
        bus_read(3, 0, "R1 rx after reset");
        bus_read(4, 0, "R1 tx after reset");
        bus_read(2, 0, "R1 busy after reset");
        bus_read(0, 0, "R1 ctrl after reset");

        // freeze and clear
        bus_write(0, 1);
        wait_done(0, "R8 first freeze");
        for (int i = 0; i < 4; i++) wr_cnt(i, 0);
        check_all("R6 clear by zero");
        bus_read(0, 1, "R7 ctrl hold bit");
        bus_read(6, 0, "R7 unmapped address");

        // mixed activity
        run_window(20, 0);
        wait_done(exp_listen(), "R8 mixed");
        check_all("R2,R3 mixed pattern");

        // R4: inputs toggle while frozen
        chan_clear = 1'b0; rx_active = 1'b1; tx_active = 1'b1;
        repeat (10) @(negedge clk);
        chan_clear = 1'b1; rx_active = 1'b0; tx_active = 1'b0;
        check_all("R4 frozen");

        // second pattern
        run_window(37, 2);
        wait_done(exp_listen(), "R8 second");
        check_all("R3 alternating clear");

        // R6: write beats increment while counting
        bus_write(0, 0);
        bus_write(1, 32'h100);
        m[0] = 32'h100;
        bus_write(0, 1);
        m[0] = sat_inc(m[0]);
        wait_done(exp_listen(), "R8 after priority");
        bus_read(1, m[0][CNT_W-1:0], "R6 write priority");

        // R5: saturation
        wr_cnt(0, 64'hFFFF_FFFD);
        wr_cnt(2, 64'hFFFF_FFFE);
        wr_cnt(1, 0);
        wr_cnt(3, 0);
        run_window(5, 2);
        wait_done(exp_listen(), "R8 saturated");
        check_all("R5 saturation");

        // R8: nonzero quotient
        wr_cnt(0, 4000000);
        wr_cnt(2, 100000);
        wr_cnt(3, 50000);
        run_window(1, 1);
        wait_done(19, "R8 listen 19 ms");
        check_all("R8 counters");

        // R9: negative difference
        wr_cnt(0, 10);
        wr_cnt(2, 100);
        wr_cnt(3, 0);
        run_window(1, 1);
        wait_done(0, "R9 clamp to zero");

        repeat (3) @(negedge clk);
        if (!ended) begin
            ended = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #(5.0 * 200000);
        if (!ended) begin
            ended = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule